// File: doc/BRIEF.md
# Two-Port Shared RAM with Address Contention Arbitration

This block is a shared memory array reached from two independent sides, called left and right. Each side has an enable, a write select, an output enable, an address and separate write and read data buses. Both sides may read or write any word in the same clock cycle. When both enabled sides present the same address, an arbiter raises a busy flag on exactly one of them. The busy side's write is dropped, so the word cannot be corrupted by two writers at once.

The arbiter settles a clash by arrival order. A side that already held an address in the previous cycle keeps it, and a newcomer to that address is marked busy. If both sides arrive in the same cycle, the left side wins. A strap input selects master or slave operation. In master mode the block's own decision drives the busy output pins. In slave mode the busy output pins stay low and the busy input pins gate writes instead. Several slaves fed from one master's busy outputs can then form a wider word under one shared decision. All accesses are synchronous to a single clock. The address and data widths are parameters, with 8 or 9 data bits as the usual setting.

Top module: `dpa_shared_ram`

## Requirements
- R1: In a single cycle, the two sides can write to, or read from, two different addresses, and both accesses take effect.
- R2: A read happens only when a side has enable=1, output enable=1 and write select=0. Its data appears on that side's read bus after the next rising clock edge. In every other cycle the read bus holds its previous value.
- R3: In master mode a busy output is high only while both sides are enabled with equal addresses. When either side is disabled or the addresses differ, both busy outputs are low.
- R4: Two sides that reach the same address in the same cycle are settled in favour of the left side: the right busy goes high and the left busy stays low. The two busy outputs are never high together.
- R5: A side that was enabled on an address in the previous cycle keeps it against a side newly arriving there, and the newcomer is busy. For as long as both sides stay on that address, the side that lost stays busy.
- R6: A write from a side whose effective busy is high leaves the memory unchanged. The winning side's write in that cycle is stored.
- R7: In slave mode (master strap=0) both busy outputs stay low. A high busy input on a side blocks that side's write, and the other side's write proceeds.
- R8: In master mode the busy inputs have no effect: a write with no address clash is stored even when that side's busy input is high.
- R9: A read issued in the cycle after the other side's write to the same address returns the newly written value.
- R10: Active-low reset clears both read buses to zero and clears the arrival history. A clash in the first cycle after reset is therefore handled as simultaneous arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | Strap: 1 = arbitrate locally and drive the busy outputs, 0 = take busy from the inputs |
| l_en | input | 1 | Left side enable |
| l_wr | input | 1 | Left side write select (1 = write) |
| l_oe | input | 1 | Left side output enable |
| l_addr | input | ADDR_W | Left side address |
| l_wdata | input | DATA_W | Left side write data |
| l_rdata | output | DATA_W | Left side registered read data |
| l_busy_o | output | 1 | Left side busy flag in master mode, 0 in slave mode |
| l_busy_i | input | 1 | Left side busy from an external master, used in slave mode |
| r_en | input | 1 | Right side enable |
| r_wr | input | 1 | Right side write select (1 = write) |
| r_oe | input | 1 | Right side output enable |
| r_addr | input | ADDR_W | Right side address |
| r_wdata | input | DATA_W | Right side write data |
| r_rdata | output | DATA_W | Right side registered read data |
| r_busy_o | output | 1 | Right side busy flag in master mode, 0 in slave mode |
| r_busy_i | input | 1 | Right side busy from an external master, used in slave mode |

## Verification
The busy outputs depend combinationally on the current inputs and the registered arrival history, so they are valid in the same cycle as the request. A write is committed on the rising edge that ends its request cycle, and read data appears after the rising edge that ends the read request cycle. A read of freshly written data therefore has to be issued one cycle after the write, and its result shows one edge later. The bench changes inputs on the falling edge, samples busy 1 ns after those changes, and samples read data at the falling edge after the relevant rising edge.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int SIDES  = 2;
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;

  // which side must yield this cycle
  typedef enum logic [1:0] {
    YIELD_NONE  = 2'b00,
    YIELD_LEFT  = 2'b01,
    YIELD_RIGHT = 2'b10
  } yield_e;
endpackage

// File: rtl/dpa_contention.sv
module dpa_contention
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_busy,
  output logic              r_busy
);
  logic              l_en_q, r_en_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  yield_e            yield_q, yield_d;
  logic              clash, l_stay, r_stay;

  assign clash  = l_en && r_en && (l_addr == r_addr);
  assign l_stay = l_en_q && (l_addr_q == l_addr);
  assign r_stay = r_en_q && (r_addr_q == r_addr);

  always_comb begin
    yield_d = YIELD_NONE;
    if (clash) begin
      unique case ({l_stay, r_stay})
        2'b10:   yield_d = YIELD_RIGHT;
        2'b01:   yield_d = YIELD_LEFT;
        2'b11:   yield_d = (yield_q == YIELD_LEFT) ? YIELD_LEFT : YIELD_RIGHT;
        default: yield_d = YIELD_RIGHT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      yield_q  <= YIELD_NONE;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      yield_q  <= yield_d;
    end
  end

  assign l_busy = (yield_d == YIELD_LEFT);
  assign r_busy = (yield_d == YIELD_RIGHT);
endmodule

// File: rtl/dpa_port_gate.sv
module dpa_port_gate (
  input  logic is_master,
  input  logic en,
  input  logic wr,
  input  logic oe,
  input  logic arb_busy,
  input  logic ext_busy,
  output logic busy_eff,
  output logic busy_pin,
  output logic we,
  output logic re
);
  assign busy_eff = is_master ? arb_busy : ext_busy;
  assign busy_pin = is_master && arb_busy;
  assign we       = en && wr && !busy_eff;
  assign re       = en && oe && !wr;
endmodule

// File: rtl/dpa_array.sv
module dpa_array
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIDES-1:0]  we,
  input  logic [SIDES-1:0]  re,
  input  logic [ADDR_W-1:0] addr  [SIDES],
  input  logic [DATA_W-1:0] wdata [SIDES],
  output logic [DATA_W-1:0] rdata [SIDES]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // left is written last so it prevails if an unarbitrated slave lets both through
  always_ff @(posedge clk) begin
    for (int p = SIDES - 1; p >= 0; p--) begin
      if (we[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar g = 0; g < SIDES; g++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata[g] <= '0;
      else if (re[g]) rdata[g] <= mem[addr[g]];
    end
  end
endmodule

// File: rtl/dpa_shared_ram.sv
module dpa_shared_ram
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_busy_o,
  input  logic              l_busy_i,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_busy_o,
  input  logic              r_busy_i
);
  logic [SIDES-1:0]  s_en, s_wr, s_oe, s_arb, s_ext, s_eff, s_pin, s_we, s_re;
  logic [ADDR_W-1:0] s_addr  [SIDES];
  logic [DATA_W-1:0] s_wdata [SIDES];
  logic [DATA_W-1:0] s_rdata [SIDES];
  logic              l_we_w, r_we_w, l_eff_w, r_eff_w;

  assign s_en  = {r_en, l_en};
  assign s_wr  = {r_wr, l_wr};
  assign s_oe  = {r_oe, l_oe};
  assign s_ext = {r_busy_i, l_busy_i};
  assign s_addr[SIDE_L]  = l_addr;
  assign s_addr[SIDE_R]  = r_addr;
  assign s_wdata[SIDE_L] = l_wdata;
  assign s_wdata[SIDE_R] = r_wdata;

  dpa_contention #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .l_en   (l_en),
    .r_en   (r_en),
    .l_addr (l_addr),
    .r_addr (r_addr),
    .l_busy (s_arb[SIDE_L]),
    .r_busy (s_arb[SIDE_R])
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dpa_port_gate u_gate (
      .is_master (is_master),
      .en        (s_en[g]),
      .wr        (s_wr[g]),
      .oe        (s_oe[g]),
      .arb_busy  (s_arb[g]),
      .ext_busy  (s_ext[g]),
      .busy_eff  (s_eff[g]),
      .busy_pin  (s_pin[g]),
      .we        (s_we[g]),
      .re        (s_re[g])
    );
  end

  dpa_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (s_we),
    .re    (s_re),
    .addr  (s_addr),
    .wdata (s_wdata),
    .rdata (s_rdata)
  );

  assign l_rdata  = s_rdata[SIDE_L];
  assign r_rdata  = s_rdata[SIDE_R];
  assign l_busy_o = s_pin[SIDE_L];
  assign r_busy_o = s_pin[SIDE_R];
  assign l_we_w   = s_we[SIDE_L];
  assign r_we_w   = s_we[SIDE_R];
  assign l_eff_w  = s_eff[SIDE_L];
  assign r_eff_w  = s_eff[SIDE_R];
endmodule

// File: rtl/dpa_shared_ram_chk.sv
module dpa_shared_ram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              is_master,
  input logic              l_en,
  input logic              l_wr,
  input logic              l_oe,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_busy_o,
  input logic              l_busy_i,
  input logic              r_en,
  input logic              r_wr,
  input logic              r_oe,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_busy_o,
  input logic              r_busy_i,
  input logic              l_we,
  input logic              r_we,
  input logic              l_eff,
  input logic              r_eff
);
  logic same;
  assign same = l_en && r_en && (l_addr == r_addr);

  p_busy_needs_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && (l_busy_o || r_busy_o) |-> same);

  p_clash_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && same |-> (l_busy_o || r_busy_o));

  p_single_loser_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy_o && r_busy_o));

  p_right_loser_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && r_busy_o |=>
      !(is_master && same && $stable(l_addr) && $stable(r_addr)) || r_busy_o);

  p_left_loser_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && l_busy_o |=>
      !(is_master && same && $stable(l_addr) && $stable(r_addr)) || l_busy_o);

  p_left_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    l_eff |-> !l_we);

  p_right_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    r_eff |-> !r_we);

  p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !l_busy_o && !r_busy_o);

  p_slave_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master && ((l_busy_i && l_we) || (r_busy_i && r_we)) |-> 1'b0);

  p_master_ignores_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && l_en && l_wr && !(r_en && r_addr == l_addr) |-> l_we);

  p_left_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_en && l_oe && !l_wr) |=> $stable(l_rdata));

  p_right_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_en && r_oe && !r_wr) |=> $stable(r_rdata));
endmodule

bind dpa_shared_ram dpa_shared_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .is_master (is_master),
  .l_en      (l_en),
  .l_wr      (l_wr),
  .l_oe      (l_oe),
  .l_addr    (l_addr),
  .l_rdata   (l_rdata),
  .l_busy_o  (l_busy_o),
  .l_busy_i  (l_busy_i),
  .r_en      (r_en),
  .r_wr      (r_wr),
  .r_oe      (r_oe),
  .r_addr    (r_addr),
  .r_rdata   (r_rdata),
  .r_busy_o  (r_busy_o),
  .r_busy_i  (r_busy_i),
  .l_we      (l_we_w),
  .r_we      (r_we_w),
  .l_eff     (l_eff_w),
  .r_eff     (r_eff_w)
);

// File: tb/dpa_shared_ram_bench.sv
`timescale 1ns/1ps
module dpa_shared_ram_bench;
  localparam int AW = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          is_master = 1'b1;
  logic          l_en = 0, l_wr = 0, l_oe = 0, l_busy_i = 0;
  logic          r_en = 0, r_wr = 0, r_oe = 0, r_busy_i = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic          l_busy_o, r_busy_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dpa_shared_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dpa_shared_ram (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_o(l_busy_o), .l_busy_i(l_busy_i),
    .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_o(r_busy_o), .r_busy_i(r_busy_i)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_l(input logic en, wr, oe, input int a, input int d);
    l_en = en; l_wr = wr; l_oe = oe; l_addr = AW'(a); l_wdata = DW'(d);
  endtask

  task automatic set_r(input logic en, wr, oe, input int a, input int d);
    r_en = en; r_wr = wr; r_oe = oe; r_addr = AW'(a); r_wdata = DW'(d);
  endtask

  task automatic idle();
    set_l(0, 0, 0, 0, 0);
    set_r(0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) step();
    chk("R10 left rdata after reset", int'(l_rdata), 0);
    chk("R10 right rdata after reset", int'(r_rdata), 0);
    rst_n = 1'b1;
    // first cycle after reset: history is empty, clash counts as a tie
    set_l(1, 0, 1, 3, 0);
    set_r(1, 0, 1, 3, 0);
    #1;
    chk("R10 first clash right busy", int'(r_busy_o), 1);
    chk("R10 first clash left free", int'(l_busy_o), 0);
    step();
    idle();
    step();
  endtask

  task automatic t_independent();
    set_l(1, 1, 0, 5, 'h11);
    set_r(1, 1, 0, 9, 'h22);
    #1;
    chk("R3 different addresses no busy", int'(l_busy_o | r_busy_o), 0);
    step();
    set_l(1, 0, 1, 9, 0);
    set_r(1, 0, 1, 5, 0);
    step();
    chk("R1 left reads right's write", int'(l_rdata), 'h22);
    chk("R1 right reads left's write", int'(r_rdata), 'h11);
    idle();
    step();
  endtask

  task automatic t_oe_gate();
    set_l(1, 0, 0, 5, 0);
    step();
    chk("R2 read without output enable holds", int'(l_rdata), 'h22);
    set_l(0, 0, 1, 5, 0);
    step();
    chk("R2 read without enable holds", int'(l_rdata), 'h22);
    set_l(1, 0, 1, 5, 0);
    step();
    chk("R2 full read lands after edge", int'(l_rdata), 'h11);
    idle();
    step();
  endtask

  task automatic t_disabled();
    set_l(0, 1, 0, 9, 'h99);
    set_r(1, 0, 1, 9, 0);
    #1;
    chk("R3 disabled side causes no busy", int'(l_busy_o | r_busy_o), 0);
    step();
    idle();
    step();
  endtask

  task automatic t_tie();
    set_l(1, 1, 0, 12, 'h33);
    set_r(1, 1, 0, 12, 'h44);
    #1;
    chk("R4 tie right busy", int'(r_busy_o), 1);
    chk("R4 tie left free", int'(l_busy_o), 0);
    step();
    idle();
    step();
    set_r(1, 0, 1, 12, 0);
    step();
    chk("R6 only winner write stored", int'(r_rdata), 'h33);
    idle();
    step();
  endtask

  task automatic t_arrival();
    set_l(1, 1, 0, 20, 'h01);
    set_r(1, 1, 0, 21, 'h02);
    step();
    idle();
    step();
    // left settles first, right arrives later with a write
    set_l(1, 0, 1, 20, 0);
    step();
    set_r(1, 1, 0, 20, 'h55);
    #1;
    chk("R5 latecomer right busy", int'(r_busy_o), 1);
    chk("R5 incumbent left free", int'(l_busy_o), 0);
    step();
    #1;
    chk("R5 right stays busy", int'(r_busy_o), 1);
    step();
    idle();
    step();
    set_l(1, 0, 1, 20, 0);
    step();
    chk("R6 busy right write dropped", int'(l_rdata), 'h01);
    idle();
    step();
    // right settles first, left arrives later
    set_r(1, 0, 1, 21, 0);
    step();
    set_l(1, 1, 0, 21, 'h66);
    #1;
    chk("R5 latecomer left busy", int'(l_busy_o), 1);
    chk("R5 incumbent right free", int'(r_busy_o), 0);
    step();
    idle();
    step();
    set_r(1, 0, 1, 21, 0);
    step();
    chk("R6 busy left write dropped", int'(r_rdata), 'h02);
    idle();
    step();
  endtask

  task automatic t_flow();
    set_l(1, 1, 0, 30, 'h77);
    step();
    set_l(0, 0, 0, 0, 0);
    set_r(1, 0, 1, 30, 0);
    step();
    chk("R9 next-cycle read sees new value", int'(r_rdata), 'h77);
    idle();
    step();
  endtask

  task automatic t_slave();
    is_master = 1'b0;
    l_busy_i = 1'b1;
    r_busy_i = 1'b0;
    set_l(1, 1, 0, 40, 'h5A);
    set_r(1, 1, 0, 40, 'hA5);
    #1;
    chk("R7 slave left busy out low", int'(l_busy_o), 0);
    chk("R7 slave right busy out low", int'(r_busy_o), 0);
    step();
    idle();
    l_busy_i = 1'b0;
    step();
    set_l(1, 0, 1, 40, 0);
    step();
    chk("R7 busy input blocked left write", int'(l_rdata), 'hA5);
    idle();
    is_master = 1'b1;
    step();
  endtask

  task automatic t_master_ignore();
    l_busy_i = 1'b1;
    r_busy_i = 1'b1;
    set_l(1, 1, 0, 42, 'h3C);
    set_r(1, 1, 0, 43, 'hC3);
    step();
    set_l(1, 0, 1, 42, 0);
    set_r(1, 0, 1, 43, 0);
    step();
    chk("R8 left write despite busy input", int'(l_rdata), 'h3C);
    chk("R8 right write despite busy input", int'(r_rdata), 'hC3);
    l_busy_i = 1'b0;
    r_busy_i = 1'b0;
    idle();
    step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_independent();
    t_oe_gate();
    t_disabled();
    t_tie();
    t_arrival();
    t_flow();
    t_slave();
    t_master_ignore();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule